// File: doc/BRIEF.md
# UART Register Bank

This block is the bus-facing register file of a UART. A processor reaches it through a simple request interface with a byte address and an access size. The block decodes word-aligned 16-bit accesses into twelve registers. It holds the divisor, control and scratch storage and drives the divisor and control values out to the UART core. It also keeps the sticky line and modem status flags and the interrupt-enable word.

Live core status (data ready, transmit holding empty, transmitter empty) is merged into the line-status view at the moment it is read. Error and break events from the core, plus a clear-to-send change, are captured as sticky flags that software clears by writing ones. The interrupt-enable word has no direct write path. Separate set and clear addresses modify it, and both addresses read it back. A write to the transmit holding address pushes a byte to the core. A read of the receive buffer address pops one byte from the core in the same cycle as the request.

Every access gets a response one cycle after its request: `bus_rvalid`, the read data, and an error flag.

Top module: `uart_regbank`

## Requirements
- R1: An access is legal only when the size code is 1 (16 bits; code 0 is 8 bits, codes 2 and 3 are wider), the address bits [1:0] are zero, and the register index (address / 4) is below 12. One cycle after any request, `bus_rvalid` is 1. In that same cycle `bus_err` is 1 exactly when the access was illegal. An illegal access returns 0 and changes no state.
- R2: After reset, index 0 (divisor low) reads 0x0001. Line status (index 5) reads 0x0060 while the core reports transmit holding empty and transmitter empty with no data ready. Every other register reads 0.
- R3: Indices 0 (divisor low), 1 (divisor high), 2 (global control), 3 (line control), 4 (modem control) and 7 (scratch) are plain 16-bit storage. A legal write is read back unchanged. Indices 0 to 4 also drive `div_lo`, `div_hi`, `gctl`, `lcr` and `mcr`.
- R4: A write to index 8 ORs the written value into the interrupt-enable word, which is visible on `ier`.
- R5: A write to index 9 clears every interrupt-enable bit written as 1. A read of index 8 or index 9 returns the current interrupt-enable word.
- R6: Line status has this layout: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 transmit holding empty, bit 6 transmitter empty, bit 7 transmit finished; bits 15:8 read 0. On a read, bits 0, 5 and 6 are the live core inputs sampled in the request cycle.
- R7: Bits 1 to 4 of line status are set by a one-cycle pulse on `core_oe`, `core_pe`, `core_fe` and `core_bi` respectively. Bit 7 is set when `core_temt` rises; its history is 1 after reset. A set in the same cycle as a clearing write wins.
- R8: A write to line status clears only the sticky bits 1, 2, 3, 4 and 7 that are written as 1. Every other written bit has no effect.
- R9: Modem status (index 6) has bit 0 as a sticky clear-to-send change flag. A `core_scts` pulse sets it, and writing 1 to bit 0 clears it. Bits 15:1 read 0, and other written bits have no effect.
- R10: A write to index 10 sets `tx_push` for exactly the next cycle, with `tx_byte` equal to the written bits [7:0]. A read of index 10 returns that byte zero-extended.
- R11: `tx_irq` is 1 in the same cycle as such a `tx_push` exactly when interrupt-enable bit 1 (transmit-empty enable) is set, and is 0 otherwise.
- R12: A legal read of index 11 drives `rx_pop` high in the request cycle and returns `rx_byte` from that cycle zero-extended. A write to index 11 pops nothing and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_size | input | 2 | Access size code, 1 = 16 bits |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Response strobe, one cycle after a request |
| bus_err | output | 1 | Illegal access flag, with bus_rvalid |
| tx_push | output | 1 | Byte handed to the transmitter |
| tx_byte | output | 8 | Byte for the transmitter |
| tx_irq | output | 1 | Transmit interrupt request pulse |
| rx_pop | output | 1 | Take the head byte from the receiver |
| rx_byte | input | 8 | Head byte offered by the receiver |
| core_dr | input | 1 | Live data-ready status |
| core_thre | input | 1 | Live transmit-holding-empty status |
| core_temt | input | 1 | Live transmitter-empty status |
| core_oe | input | 1 | Overrun event pulse |
| core_pe | input | 1 | Parity error event pulse |
| core_fe | input | 1 | Framing error event pulse |
| core_bi | input | 1 | Break event pulse |
| core_scts | input | 1 | Clear-to-send change event pulse |
| div_lo | output | 16 | Divisor low register |
| div_hi | output | 16 | Divisor high register |
| gctl | output | 16 | Global control register |
| lcr | output | 16 | Line control register |
| mcr | output | 16 | Modem control register |
| ier | output | 16 | Interrupt-enable word |

## Verification
The bench builds the block with its default 8-bit address. That width leaves room for indices 12 to 63, so accesses beyond the last register decode, and accesses to unmapped space can be aimed at. The register widths are fixed by the line-status layout, so only the address width is varied. With that address width, every register, the misaligned offsets and the unmapped indices can all be reached, and the bench follows each cycle with its own model.

// File: rtl/uart_regbank_pkg.sv
package uart_regbank_pkg;

  localparam int REG_W    = 16;
  localparam int CHAR_W   = 8;
  localparam int NUM_REGS = 12;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int NUM_PLAIN = 6;

  typedef enum logic [IDX_W-1:0] {
    RI_DIVLO  = 4'd0,
    RI_DIVHI  = 4'd1,
    RI_GCTL   = 4'd2,
    RI_LINE   = 4'd3,
    RI_MODEM  = 4'd4,
    RI_LSTAT  = 4'd5,
    RI_MSTAT  = 4'd6,
    RI_SCRAT  = 4'd7,
    RI_IESET  = 4'd8,
    RI_IECLR  = 4'd9,
    RI_TXH    = 4'd10,
    RI_RXB    = 4'd11
  } reg_idx_e;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  // line status bit positions
  localparam int LS_DR   = 0;
  localparam int LS_OE   = 1;
  localparam int LS_PE   = 2;
  localparam int LS_FE   = 3;
  localparam int LS_BI   = 4;
  localparam int LS_THRE = 5;
  localparam int LS_TEMT = 6;
  localparam int LS_TFI  = 7;
  localparam int IE_TXEMPTY = 1;

  localparam logic [CHAR_W-1:0] LS_STICKY_MASK =
    CHAR_W'((1 << LS_OE) | (1 << LS_PE) | (1 << LS_FE) | (1 << LS_BI) | (1 << LS_TFI));

  localparam logic [REG_W-1:0] DIVLO_RESET = 16'h0001;

  function automatic logic [REG_W-1:0] ie_or(input logic [REG_W-1:0] cur,
                                             input logic [REG_W-1:0] val);
    return cur | val;
  endfunction

  function automatic logic [REG_W-1:0] ie_andnot(input logic [REG_W-1:0] cur,
                                                 input logic [REG_W-1:0] val);
    return cur & ~val;
  endfunction

  function automatic logic [CHAR_W-1:0] sticky_next(input logic [CHAR_W-1:0] cur,
                                                    input logic [CHAR_W-1:0] clr,
                                                    input logic [CHAR_W-1:0] set);
    return ((cur & ~(clr & LS_STICKY_MASK)) | set) & LS_STICKY_MASK;
  endfunction

  function automatic logic [REG_W-1:0] lstat_view(input logic [CHAR_W-1:0] sticky,
                                                  input logic dr,
                                                  input logic thre,
                                                  input logic temt);
    logic [REG_W-1:0] v;
    v = {{(REG_W-CHAR_W){1'b0}}, sticky & LS_STICKY_MASK};
    v[LS_DR]   = dr;
    v[LS_THRE] = thre;
    v[LS_TEMT] = temt;
    return v;
  endfunction

endpackage

// File: rtl/uart_regbank_decode.sv
module uart_regbank_decode
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_idx_e          idx,
  output logic              hit,
  output logic              fault
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic in_map, aligned, size_ok, legal;

  assign word    = addr[ADDR_W-1:2];
  assign in_map  = (word < WORD_W'(NUM_REGS));
  assign aligned = (addr[1:0] == 2'b00);
  assign size_ok = (size == SIZE_HALF);
  assign legal   = in_map & aligned & size_ok;
  assign idx     = reg_idx_e'(word[IDX_W-1:0]);
  assign hit     = req & legal;
  assign fault   = req & ~legal;
endmodule

// File: rtl/uart_regbank_status.sv
module uart_regbank_status
  import uart_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lstat_wr,
  input  logic              mstat_wr,
  input  logic [CHAR_W-1:0] wbyte,
  input  logic              ev_oe,
  input  logic              ev_pe,
  input  logic              ev_fe,
  input  logic              ev_bi,
  input  logic              ev_scts,
  input  logic              live_temt,
  output logic [CHAR_W-1:0] sticky_q,
  output logic              scts_q,
  output logic              tfi_set
);
  logic              temt_hist_q;
  logic [CHAR_W-1:0] set_v;
  logic [CHAR_W-1:0] clr_v;

  assign tfi_set = live_temt & ~temt_hist_q;

  always_comb begin
    set_v         = '0;
    set_v[LS_OE]  = ev_oe;
    set_v[LS_PE]  = ev_pe;
    set_v[LS_FE]  = ev_fe;
    set_v[LS_BI]  = ev_bi;
    set_v[LS_TFI] = tfi_set;
    clr_v         = lstat_wr ? wbyte : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temt_hist_q <= 1'b1;
      sticky_q    <= '0;
      scts_q      <= 1'b0;
    end else begin
      temt_hist_q <= live_temt;
      sticky_q    <= sticky_next(sticky_q, clr_v, set_v);
      scts_q      <= ev_scts | (scts_q & ~(mstat_wr & wbyte[0]));
    end
  end
endmodule

// File: rtl/uart_regbank_ie.sv
module uart_regbank_ie
  import uart_regbank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_wr,
  input  logic             clr_wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] ie_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ie_q <= '0;
    else if (set_wr) ie_q <= ie_or(ie_q, wdata);
    else if (clr_wr) ie_q <= ie_andnot(ie_q, wdata);
  end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              tx_push,
  output logic [7:0]        tx_byte,
  output logic              tx_irq,
  output logic              rx_pop,
  input  logic [7:0]        rx_byte,
  input  logic              core_dr,
  input  logic              core_thre,
  input  logic              core_temt,
  input  logic              core_oe,
  input  logic              core_pe,
  input  logic              core_fe,
  input  logic              core_bi,
  input  logic              core_scts,
  output logic [15:0]       div_lo,
  output logic [15:0]       div_hi,
  output logic [15:0]       gctl,
  output logic [15:0]       lcr,
  output logic [15:0]       mcr,
  output logic [15:0]       ier
);
  localparam reg_idx_e PLAIN_IDX [NUM_PLAIN] =
    '{RI_DIVLO, RI_DIVHI, RI_GCTL, RI_LINE, RI_MODEM, RI_SCRAT};

  // named internal events
  reg_idx_e          acc_idx;
  logic              acc_hit, acc_fault;
  logic              wr_hit, rd_hit;
  logic              wr_lstat, wr_mstat, wr_ieset, wr_ieclr, wr_txh;
  logic              rd_rxb;
  logic [CHAR_W-1:0] lsr_sticky;
  logic              scts_q;
  logic              tfi_set;
  logic [REG_W-1:0]  plain_q [NUM_PLAIN];
  logic [CHAR_W-1:0] txh_q;
  logic [REG_W-1:0]  rd_mux;

  uart_regbank_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req   (bus_req),
    .addr  (bus_addr),
    .size  (bus_size),
    .idx   (acc_idx),
    .hit   (acc_hit),
    .fault (acc_fault)
  );

  assign wr_hit   = acc_hit & bus_we;
  assign rd_hit   = acc_hit & ~bus_we;
  assign wr_lstat = wr_hit & (acc_idx == RI_LSTAT);
  assign wr_mstat = wr_hit & (acc_idx == RI_MSTAT);
  assign wr_ieset = wr_hit & (acc_idx == RI_IESET);
  assign wr_ieclr = wr_hit & (acc_idx == RI_IECLR);
  assign wr_txh   = wr_hit & (acc_idx == RI_TXH);
  assign rd_rxb   = rd_hit & (acc_idx == RI_RXB);
  assign rx_pop   = rd_rxb;

  uart_regbank_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .lstat_wr  (wr_lstat),
    .mstat_wr  (wr_mstat),
    .wbyte     (bus_wdata[CHAR_W-1:0]),
    .ev_oe     (core_oe),
    .ev_pe     (core_pe),
    .ev_fe     (core_fe),
    .ev_bi     (core_bi),
    .ev_scts   (core_scts),
    .live_temt (core_temt),
    .sticky_q  (lsr_sticky),
    .scts_q    (scts_q),
    .tfi_set   (tfi_set)
  );

  uart_regbank_ie u_ie (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_wr (wr_ieset),
    .clr_wr (wr_ieclr),
    .wdata  (bus_wdata),
    .ie_q   (ier)
  );

  // plain storage registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : g_plain
    localparam logic [REG_W-1:0] RST_VAL = (g == 0) ? DIVLO_RESET : '0;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   plain_q[g] <= RST_VAL;
      else if (wr_hit && acc_idx == PLAIN_IDX[g])   plain_q[g] <= bus_wdata;
    end
  end

  assign div_lo = plain_q[0];
  assign div_hi = plain_q[1];
  assign gctl   = plain_q[2];
  assign lcr    = plain_q[3];
  assign mcr    = plain_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      txh_q <= '0;
    else if (wr_txh) txh_q <= bus_wdata[CHAR_W-1:0];
  end

  always_comb begin
    rd_mux = '0;
    unique case (acc_idx)
      RI_DIVLO:          rd_mux = plain_q[0];
      RI_DIVHI:          rd_mux = plain_q[1];
      RI_GCTL:           rd_mux = plain_q[2];
      RI_LINE:           rd_mux = plain_q[3];
      RI_MODEM:          rd_mux = plain_q[4];
      RI_SCRAT:          rd_mux = plain_q[5];
      RI_LSTAT:          rd_mux = lstat_view(lsr_sticky, core_dr, core_thre, core_temt);
      RI_MSTAT:          rd_mux = {{(REG_W-1){1'b0}}, scts_q};
      RI_IESET, RI_IECLR: rd_mux = ier;
      RI_TXH:            rd_mux = {{(REG_W-CHAR_W){1'b0}}, txh_q};
      RI_RXB:            rd_mux = {{(REG_W-CHAR_W){1'b0}}, rx_byte};
      default:           rd_mux = '0;
    endcase
  end

  // response and transmit-side registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      bus_rdata  <= '0;
      tx_push    <= 1'b0;
      tx_byte    <= '0;
      tx_irq     <= 1'b0;
    end else begin
      bus_rvalid <= bus_req;
      bus_err    <= acc_fault;
      bus_rdata  <= rd_hit ? rd_mux : '0;
      tx_push    <= wr_txh;
      tx_irq     <= wr_txh & ier[IE_TXEMPTY];
      if (wr_txh) tx_byte <= bus_wdata[CHAR_W-1:0];
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk
  import uart_regbank_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [15:0]       bus_wdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              tx_push,
  input logic              tx_irq,
  input logic              rx_pop,
  input logic [15:0]       ier,
  input logic [15:0]       div_lo,
  input logic              wr_hit,
  input reg_idx_e          acc_idx,
  input logic [CHAR_W-1:0] lsr_sticky,
  input logic              scts_q,
  input logic              core_oe,
  input logic              core_scts
);
  assert_resp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_rvalid);

  assert_err_not_push_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !tx_push);

  assert_divlo_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_hit && acc_idx == RI_DIVLO) |=> $stable(div_lo));

  assert_ieset_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_idx == RI_IESET) |=> ((ier & $past(bus_wdata)) == $past(bus_wdata)));

  assert_ieclr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && acc_idx == RI_IECLR) |=> ((ier & $past(bus_wdata)) == 16'h0000));

  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    core_oe |=> lsr_sticky[LS_OE]);

  assert_scts_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    core_scts |=> scts_q);

  assert_irq_with_push_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> tx_push);

  assert_pop_on_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_req && !bus_we));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rvalid (bus_rvalid),
  .bus_err    (bus_err),
  .tx_push    (tx_push),
  .tx_irq     (tx_irq),
  .rx_pop     (rx_pop),
  .ier        (ier),
  .div_lo     (div_lo),
  .wr_hit     (wr_hit),
  .acc_idx    (acc_idx),
  .lsr_sticky (lsr_sticky),
  .scts_q     (scts_q),
  .core_oe    (core_oe),
  .core_scts  (core_scts)
);

// File: tb/sim_uart_regbank.sv
`timescale 1ns/1ps
module sim_uart_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [1:0]  size = 2'd1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rvalid, err, tx_push, tx_irq, rx_pop;
  logic [7:0]  tx_byte;
  logic [7:0]  rx_byte = 8'h00;
  logic        dr = 1'b0, thre = 1'b1, temt = 1'b1;
  logic        oe = 1'b0, pe = 1'b0, fe = 1'b0, bi = 1'b0, scts = 1'b0;
  logic [15:0] div_lo, div_hi, gctl, lcr, mcr, ier;

  int checks = 0;
  int errors = 0;
  int pops = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uart_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata), .bus_rvalid(rvalid),
    .bus_err(err), .tx_push(tx_push), .tx_byte(tx_byte), .tx_irq(tx_irq),
    .rx_pop(rx_pop), .rx_byte(rx_byte), .core_dr(dr), .core_thre(thre),
    .core_temt(temt), .core_oe(oe), .core_pe(pe), .core_fe(fe), .core_bi(bi),
    .core_scts(scts), .div_lo(div_lo), .div_hi(div_hi), .gctl(gctl), .lcr(lcr),
    .mcr(mcr), .ier(ier)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_reg [12];
  int m_ier;
  bit s_oe, s_pe, s_fe, s_bi, s_tfi, s_scts, prev_temt;
  bit e_rvalid, e_err, e_push, e_irq;
  int e_rdata, e_txb;
  string e_rtag = "R2";
  int ix;
  bit ok;

  function automatic string tag_of(input int i);
    case (i)
      5: return "R6";
      6: return "R9";
      8, 9: return "R5";
      10: return "R10";
      11: return "R12";
      default: return "R3";
    endcase
  endfunction

  function automatic bit legal_now();
    return req && (addr[1:0] == 2'b00) && ((int'(addr) >> 2) < 12) && (size == 2'd1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_reg[k]) m_reg[k] = 0;
      m_reg[0] = 1;
      m_ier = 0;
      {s_oe, s_pe, s_fe, s_bi, s_tfi, s_scts} = '0;
      prev_temt = 1;
      {e_rvalid, e_err, e_push, e_irq} = '0;
      e_rdata = 0;
      e_txb = 0;
    end else begin
      ix = int'(addr) >> 2;
      ok = legal_now();
      e_rvalid = req;
      e_err = req && !ok;
      e_rdata = 0;
      e_push = 0;
      e_irq = 0;
      if (ok && !we) begin
        e_rtag = tag_of(ix);
        case (ix)
          5: e_rdata = int'(dr) | (int'(s_oe) << 1) | (int'(s_pe) << 2) | (int'(s_fe) << 3) |
                       (int'(s_bi) << 4) | (int'(thre) << 5) | (int'(temt) << 6) | (int'(s_tfi) << 7);
          6: e_rdata = int'(s_scts);
          8, 9: e_rdata = m_ier;
          11: e_rdata = int'(rx_byte);
          default: e_rdata = m_reg[ix];
        endcase
      end
      if (ok && we) begin
        case (ix)
          5: begin
            if (wdata[1]) s_oe = 0;
            if (wdata[2]) s_pe = 0;
            if (wdata[3]) s_fe = 0;
            if (wdata[4]) s_bi = 0;
            if (wdata[7]) s_tfi = 0;
          end
          6: if (wdata[0]) s_scts = 0;
          8: m_ier = m_ier | int'(wdata);
          9: m_ier = m_ier & ~int'(wdata) & 16'hFFFF;
          10: begin
            m_reg[10] = int'(wdata) & 8'hFF;
            e_push = 1;
            e_txb = int'(wdata) & 8'hFF;
            e_irq = m_ier[1];
          end
          11: ;
          default: m_reg[ix] = int'(wdata);
        endcase
      end
      if (oe) s_oe = 1;
      if (pe) s_pe = 1;
      if (fe) s_fe = 1;
      if (bi) s_bi = 1;
      if (scts) s_scts = 1;
      if (temt && !prev_temt) s_tfi = 1;
      prev_temt = temt;
    end
  end

  // compare against the model every cycle, away from the edges
  always begin
    @(negedge clk);
    #1;
    if (rst_n && !finished) begin
      chk("R1", "rvalid", int'(rvalid), int'(e_rvalid));
      chk("R1", "err", int'(err), int'(e_err));
      chk(e_rtag, "rdata", int'(rdata), e_rdata);
      chk("R10", "tx_push", int'(tx_push), int'(e_push));
      if (e_push) chk("R10", "tx_byte", int'(tx_byte), e_txb);
      chk("R11", "tx_irq", int'(tx_irq), int'(e_irq));
      chk("R12", "rx_pop", int'(rx_pop), int'(legal_now() && !we && ((int'(addr) >> 2) == 11)));
      chk("R3", "div_lo", int'(div_lo), m_reg[0]);
      chk("R3", "div_hi", int'(div_hi), m_reg[1]);
      chk("R3", "gctl", int'(gctl), m_reg[2]);
      chk("R3", "lcr", int'(lcr), m_reg[3]);
      chk("R3", "mcr", int'(mcr), m_reg[4]);
      chk("R4", "ier", int'(ier), m_ier);
    end
  end

  always @(posedge clk) if (rx_pop) pops++;

  // ---------------- stimulus helpers ----------------
  task automatic acc(input bit w, input int a, input int sz, input int d, output int rd);
    req = 1'b1; we = w; addr = 8'(a); size = 2'(sz); wdata = 16'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0; size = 2'd1;
    rd = int'(rdata);
  endtask

  task automatic wr(input int a, input int d);
    int unused;
    acc(1'b1, a, 1, d, unused);
  endtask

  task automatic rd(input int a, output int v);
    acc(1'b0, a, 1, 0, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int v;
    int p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(1);

    // R2 reset state
    rd(0, v);  chk("R2", "reset divisor low", v, 16'h0001);
    rd(20, v); chk("R2", "reset line status", v, 16'h0060);
    rd(12, v); chk("R2", "reset line control", v, 0);
    rd(24, v); chk("R2", "reset modem status", v, 0);
    rd(32, v); chk("R2", "reset enables", v, 0);
    rd(40, v); chk("R2", "reset tx holding", v, 0);

    // R3 plain storage
    foreach (m_reg[k]) begin
      if (k <= 4 || k == 7) begin
        wr(k * 4, 16'hA5A0 + k);
        rd(k * 4, v);
        chk("R3", "plain readback", v, 16'hA5A0 + k);
      end
    end
    chk("R3", "divisor low output", int'(div_lo), 16'hA5A0);

    // R4 / R5 enable set and clear aliases
    wr(32, 16'h0005);
    wr(32, 16'h0002);
    rd(36, v); chk("R5", "enables via clear alias", v, 16'h0007);
    wr(36, 16'h0004);
    rd(32, v); chk("R4", "enables via set alias", v, 16'h0003);

    // R10 / R11 transmit
    wr(40, 16'h1234);
    chk("R10", "push after write", int'(tx_push), 1);
    chk("R10", "pushed byte", int'(tx_byte), 16'h34);
    chk("R11", "irq with enable", int'(tx_irq), 1);
    wr(36, 16'h0002);
    wr(40, 16'h0056);
    chk("R11", "no irq without enable", int'(tx_irq), 0);
    rd(40, v); chk("R10", "tx holding readback", v, 16'h0056);

    // R12 receive
    rx_byte = 8'h9C;
    p0 = pops;
    rd(44, v); chk("R12", "receive byte", v, 16'h009C);
    chk("R12", "one pop", pops - p0, 1);
    wr(44, 16'h00FF);
    chk("R12", "write pops nothing", pops - p0, 1);
    chk("R12", "write sends nothing", int'(tx_push), 0);

    // R6 live merge and R7 TFI on TEMT rise
    dr = 1'b1; thre = 1'b0; temt = 1'b0;
    idle(1);
    rd(20, v); chk("R6", "live bits merged", v, 16'h0001);
    dr = 1'b0; thre = 1'b1; temt = 1'b1;
    idle(1);
    rd(20, v); chk("R7", "finish flag on temt rise", v, 16'h00E0);

    // R7 event pulses
    oe = 1; pe = 1; idle(1); oe = 0; pe = 0;
    fe = 1; bi = 1; idle(1); fe = 0; bi = 0;
    rd(20, v); chk("R7", "error flags sticky", v, 16'h00FE);

    // R8 write-one-to-clear
    wr(20, 16'hFF61);
    rd(20, v); chk("R8", "non-sticky writes ignored", v, 16'h00FE);
    wr(20, 16'h0006);
    rd(20, v); chk("R8", "clear overrun and parity", v, 16'h00F8);
    wr(20, 16'h0098);
    rd(20, v); chk("R8", "clear remaining", v, 16'h0060);
    oe = 1;
    wr(20, 16'h0002);
    oe = 0;
    rd(20, v); chk("R7", "set wins over clear", v, 16'h0062);

    // R9 modem status
    scts = 1; idle(1); scts = 0;
    rd(24, v); chk("R9", "cts change sticky", v, 16'h0001);
    wr(24, 16'hFFFE);
    rd(24, v); chk("R9", "other bits ignored", v, 16'h0001);
    wr(24, 16'h0001);
    rd(24, v); chk("R9", "cts change cleared", v, 0);

    // R1 illegal accesses
    acc(1'b1, 28, 0, 16'hBEEF, v);
    chk("R1", "byte size flagged", int'(err), 1);
    rd(28, v); chk("R1", "byte write had no effect", v, 16'hA5A7);
    chk("R1", "legal access not flagged", int'(err), 0);
    acc(1'b1, 30, 1, 16'h1111, v);
    chk("R1", "misaligned flagged", int'(err), 1);
    acc(1'b0, 48, 1, 0, v);
    chk("R1", "unmapped flagged", int'(err), 1);
    chk("R1", "unmapped reads zero", v, 0);
    acc(1'b0, 0, 2, 0, v);
    chk("R1", "wide size flagged", int'(err), 1);
    chk("R1", "wide read returns zero", v, 0);
    acc(1'b1, 40, 3, 16'h0077, v);
    chk("R1", "illegal tx write no push", int'(tx_push), 0);

    idle(3);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule